// File: doc/BRIEF.md
# Token-Passing Serial Readout Controller

This controller empties one front-end chip's event store onto a serial data line that several chips share. The chips form a chain. A token enters the first chip from the acquisition system, or enters a later chip from its upstream neighbour. While the controller holds the token it enables its line driver. It then sends its chip identifier and the number of stored event columns. After that, for each column from the newest to the oldest, it sends the bunch-crossing tag followed by one record for every channel. When the last bit is out, it releases the line and sends a one-cycle token pulse to the next chip.

The event store sits outside this block and is read through a combinational port. The controller places a column index and a channel index on that port, and the store returns the column's bunch-crossing tag and the addressed channel record in the same cycle. Reset removes the token, so no chip drives the line until a new start arrives.

Top module: `token_readout`

## Requirements
- R1: While reset is held, and after it is released, `sdata_oe`, `xmit_on`, `token_out` and `sdata` are all low until a token is accepted.
- R2: A `token_in` high at a rising edge while idle is accepted. `sdata_oe` and `xmit_on` are high from that edge on, and the first frame bit appears on `sdata` at once.
- R3: A frame opens with the 8-bit chip identifier and then the 5-bit stored-column count, each sent MSB first, one bit per clock.
- R4: Columns are sent from index count-1 (newest) down to index 0 (oldest). Each column starts with its 12-bit bunch-crossing tag, sent MSB first.
- R5: After its tag, each column carries 36 records in channel order 0 to 35. Each record is 14 bits, sent MSB first: bit 13 is hit, bit 12 is gain range, and bits 11:0 are the converted value.
- R6: A frame is 13 + count*516 bit cycles long, and `sdata_oe` stays high for exactly that many cycles.
- R7: With a count of zero, only the identifier and the zero count are sent (13 cycles), and the token is then passed on.
- R8: At the edge after the last bit, `sdata_oe` and `xmit_on` fall and `token_out` is high for exactly one cycle.
- R9: A `token_in` that arrives while a frame is in progress has no effect. The frame continues unchanged, and no second frame follows it.
- R10: `sdata` is low whenever `sdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| token_in | input | 1 | Start token from the acquisition system or the previous chip |
| chip_id | input | 8 | Identifier sent at the head of the frame |
| col_count | input | 5 | Number of stored columns (0 to 16), sampled when the token is accepted |
| rd_col | output | 4 | Column index presented to the event store |
| rd_chan | output | 6 | Channel index presented to the event store |
| rd_bcid | input | 12 | Bunch-crossing tag of column `rd_col` |
| rd_rec | input | 14 | Record {hit, gain, value} of channel `rd_chan` in column `rd_col` |
| sdata | output | 1 | Serial frame data |
| sdata_oe | output | 1 | Line driver enable; high only while the token is held |
| xmit_on | output | 1 | Transmit-active flag for the system |
| token_out | output | 1 | One-cycle pulse that hands the token to the next chip |

## Verification
The assertions assume three things: `col_count` never exceeds the store depth; the store answers a new address within the same cycle; and `token_in` is a level sampled at clock edges, so it may stay high for any number of cycles. The stimulus meets these assumptions. It drives inputs only on falling edges. Its store model is a combinational function of `rd_col` and `rd_chan`. It uses counts of 0, 1, 2, 3 and the full depth of 16. One run raises a stray token in the middle of a frame to exercise the busy case.

// File: rtl/token_readout_pkg.sv
package token_readout_pkg;

  typedef enum logic [1:0] {
    FLD_ID   = 2'd0,
    FLD_CNT  = 2'd1,
    FLD_BCID = 2'd2,
    FLD_REC  = 2'd3
  } field_e;

  // Largest of four widths: sizes the shared shift register.
  function automatic int widest(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Bits occupied by one column: tag plus every channel record.
  function automatic int column_bits(input int tag_w, input int nch, input int rec_w);
    return tag_w + nch * rec_w;
  endfunction

  // Total bit cycles of a frame carrying ncols columns.
  function automatic int frame_bits(input int id_w, input int cnt_w, input int ncols,
                                    input int tag_w, input int nch, input int rec_w);
    return id_w + cnt_w + ncols * column_bits(tag_w, nch, rec_w);
  endfunction

endpackage

// File: rtl/rdo_shifter.sv
module rdo_shifter #(
  parameter int SH_W  = 14,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SH_W-1:0]  load_val,
  input  logic [LEN_W-1:0] load_len,
  input  logic             shift,
  output logic             bit_out,
  output logic             last_bit,
  output logic [LEN_W-1:0] left
);

  logic [SH_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (load) begin
      sh   <= load_val;
      left <= load_len;
    end else if (shift) begin
      sh   <= {sh[SH_W-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  assign bit_out  = sh[SH_W-1];
  assign last_bit = (left == LEN_W'(1));

endmodule

// File: rtl/rdo_walker.sv
module rdo_walker #(
  parameter int NCH   = 36,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int COLW = $clog2(DEPTH),
  localparam int CHW  = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CW-1:0]   start_cnt,
  input  logic            rec_step,
  output logic [COLW-1:0] col,
  output logic [CHW-1:0]  chan,
  output logic [CW-1:0]   cols_left
);

  wire last_chan = (chan == CHW'(NCH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col       <= '0;
      chan      <= '0;
      cols_left <= '0;
    end else if (start) begin
      col       <= (start_cnt == '0) ? '0 : COLW'(start_cnt - 1'b1);
      chan      <= '0;
      cols_left <= start_cnt;
    end else if (rec_step) begin
      if (last_chan) begin
        chan      <= '0;
        cols_left <= cols_left - 1'b1;
        if (cols_left > CW'(1)) col <= col - 1'b1;
      end else begin
        chan <= chan + 1'b1;
      end
    end
  end

  // R5
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan < CHW'(NCH));

  // R4
  col_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_step && last_chan && cols_left > CW'(1)) |=> (col == $past(col) - 1'b1));

endmodule

// File: rtl/token_readout.sv
module token_readout
  import token_readout_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int NCH    = 36,
  parameter int DEPTH  = 16,
  parameter int VAL_W  = 12,
  parameter int TAG_W  = 12,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int COLW  = $clog2(DEPTH),
  localparam int CHW   = $clog2(NCH),
  localparam int REC_W = VAL_W + 2,
  localparam int SH_W  = widest(ID_W, CW, TAG_W, REC_W),
  localparam int LEN_W = $clog2(SH_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             token_in,
  input  logic [ID_W-1:0]  chip_id,
  input  logic [CW-1:0]    col_count,
  output logic [COLW-1:0]  rd_col,
  output logic [CHW-1:0]   rd_chan,
  input  logic [TAG_W-1:0] rd_bcid,
  input  logic [REC_W-1:0] rd_rec,
  output logic             sdata,
  output logic             sdata_oe,
  output logic             xmit_on,
  output logic             token_out
);

  logic            active;
  field_e          field;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   cols_left;
  logic            bit_now, last_bit;
  logic [LEN_W-1:0] left;

  // Named events used by the datapath and the assertions.
  wire accept     = token_in && !active;
  wire field_end  = active && last_bit;
  wire col_done   = (rd_chan == '0);
  wire finish     = field_end &&
                    ((field == FLD_CNT && cnt_q == '0) ||
                     (field == FLD_REC && col_done && cols_left == '0));
  wire go_tag     = field_end &&
                    ((field == FLD_CNT && cnt_q != '0) ||
                     (field == FLD_REC && col_done && cols_left != '0));
  wire go_rec     = field_end &&
                    (field == FLD_BCID || (field == FLD_REC && !col_done));
  wire go_cnt     = field_end && field == FLD_ID;

  logic             ld;
  logic [SH_W-1:0]  ld_val;
  logic [LEN_W-1:0] ld_len;

  always_comb begin
    ld     = 1'b1;
    ld_val = '0;
    ld_len = '0;
    if (accept) begin
      ld_val = SH_W'(chip_id) << (SH_W - ID_W);
      ld_len = LEN_W'(ID_W);
    end else if (go_cnt) begin
      ld_val = SH_W'(cnt_q) << (SH_W - CW);
      ld_len = LEN_W'(CW);
    end else if (go_tag) begin
      ld_val = SH_W'(rd_bcid) << (SH_W - TAG_W);
      ld_len = LEN_W'(TAG_W);
    end else if (go_rec) begin
      ld_val = SH_W'(rd_rec) << (SH_W - REC_W);
      ld_len = LEN_W'(REC_W);
    end else begin
      ld = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      field     <= FLD_ID;
      cnt_q     <= '0;
      token_out <= 1'b0;
    end else begin
      token_out <= 1'b0;
      if (accept) begin
        active <= 1'b1;
        field  <= FLD_ID;
        cnt_q  <= col_count;
      end else if (finish) begin
        active    <= 1'b0;
        token_out <= 1'b1;
      end else if (go_cnt) begin
        field <= FLD_CNT;
      end else if (go_tag) begin
        field <= FLD_BCID;
      end else if (go_rec) begin
        field <= FLD_REC;
      end
    end
  end

  rdo_shifter #(.SH_W(SH_W), .LEN_W(LEN_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld && !finish),
    .load_val (ld_val),
    .load_len (ld_len),
    .shift    (active && !ld),
    .bit_out  (bit_now),
    .last_bit (last_bit),
    .left     (left)
  );

  rdo_walker #(.NCH(NCH), .DEPTH(DEPTH)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .start_cnt (col_count),
    .rec_step  (go_rec),
    .col       (rd_col),
    .chan      (rd_chan),
    .cols_left (cols_left)
  );

  assign sdata_oe = active;
  assign xmit_on  = active;
  assign sdata    = active & bit_now;

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (token_in && !sdata_oe) |=> sdata_oe);

  // R8
  token_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    token_out |-> (!sdata_oe && $past(sdata_oe)));

  // R8
  token_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    token_out |=> !token_out);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(cnt_q));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata);

  // R6
  bit_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (left != '0));

endmodule

// File: tb/token_readout_test.sv
`timescale 1ns/1ps
module token_readout_test;

  localparam int NCH = 36;
  localparam int COLB = 12 + NCH * 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        token_in = 1'b0;
  logic [7:0]  chip_id = '0;
  logic [4:0]  col_count = '0;
  logic [3:0]  rd_col;
  logic [5:0]  rd_chan;
  logic [11:0] rd_bcid;
  logic [13:0] rd_rec;
  logic        sdata, sdata_oe, xmit_on, token_out;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  function automatic logic [11:0] mem_tag(input int c);
    return 12'((c * 293 + 77) % 4096);
  endfunction

  function automatic logic [13:0] mem_rec(input int c, input int ch);
    logic h, g;
    h = ((c + ch) % 3) == 0;
    g = ((c ^ ch) & 1) == 1;
    return {h, g, 12'((c * 251 + ch * 173 + 9) % 4096)};
  endfunction

  assign rd_bcid = mem_tag(int'(rd_col));
  assign rd_rec  = mem_rec(int'(rd_col), int'(rd_chan));

  token_readout uut (
    .clk(clk), .rst_n(rst_n), .token_in(token_in), .chip_id(chip_id),
    .col_count(col_count), .rd_col(rd_col), .rd_chan(rd_chan),
    .rd_bcid(rd_bcid), .rd_rec(rd_rec), .sdata(sdata), .sdata_oe(sdata_oe),
    .xmit_on(xmit_on), .token_out(token_out)
  );

  function automatic logic exp_bit(input logic [7:0] id, input int cnt, input int i);
    int k, ord, r, c, ch, b;
    logic [13:0] rec;
    logic [11:0] tag;
    logic [4:0] cv;
    if (i < 8) return id[7 - i];
    cv = 5'(cnt);
    if (i < 13) return cv[4 - (i - 8)];
    k = i - 13;
    ord = k / COLB;
    r = k % COLB;
    c = cnt - 1 - ord;
    if (r < 12) begin
      tag = mem_tag(c);
      return tag[11 - r];
    end
    ch = (r - 12) / 14;
    b = (r - 12) % 14;
    rec = mem_rec(c, ch);
    return rec[13 - b];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [7:0] id, input int cnt, input bit stray);
    int idx, bad, bad_idx, bad_act, bad_exp, want;
    string tag;
    tag = (cnt == 0) ? "R7" : "R3/R4/R5";
    want = 13 + cnt * COLB;
    @(negedge clk);
    chip_id = id;
    col_count = 5'(cnt);
    token_in = 1'b1;
    @(negedge clk);
    token_in = 1'b0;
    // R2: driver on one edge after acceptance
    check(sdata_oe && xmit_on, "R2", int'(sdata_oe), 1);
    idx = 0;
    bad = 0;
    bad_idx = 0; bad_act = 0; bad_exp = 0;
    while (sdata_oe && idx < 20000) begin
      token_in = stray && (idx == 40 || idx == 41);
      if (sdata !== exp_bit(id, cnt, idx)) begin
        if (bad == 0) begin
          bad_idx = idx; bad_act = int'(sdata); bad_exp = int'(exp_bit(id, cnt, idx));
        end
        bad++;
      end
      idx++;
      @(negedge clk);
    end
    token_in = 1'b0;
    if (bad != 0) $display("  first mismatch at bit %0d", bad_idx);
    check(bad == 0, tag, bad_act, bad_exp);
    // R6: frame length
    check(idx == want, "R6", idx, want);
    // R8: pass pulse when the driver releases
    check(token_out === 1'b1 && !xmit_on, "R8", int'(token_out), 1);
    @(negedge clk);
    check(token_out === 1'b0, "R8", int'(token_out), 0);
    // R10: line quiet when not driven
    check(!sdata_oe && sdata === 1'b0, "R10", int'(sdata), 0);
    repeat (3) @(negedge clk);
    if (stray) begin
      // R9: stray token mid-frame starts no second frame
      check(!sdata_oe && !token_out, "R9", int'(sdata_oe), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet while reset held
    check(!sdata_oe && !xmit_on && !token_out && !sdata, "R1", int'(sdata_oe), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!sdata_oe && !xmit_on && !token_out && !sdata, "R1", int'(sdata_oe), 0);
    run_frame(8'hA5, 0, 1'b0);
    run_frame(8'h3C, 1, 1'b0);
    run_frame(8'h01, 2, 1'b1);
    run_frame(8'h80, 3, 1'b0);
    run_frame(8'hFF, 16, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule